// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and a 64K x 8 asynchronous static RAM. The RAM is selected through two enables of opposite polarity: an active-low select and an active-high select. It also takes an active-low write strobe and an active-low read enable. The host issues a single-cycle request that carries a write flag, an address and write data. The controller then runs the strobe sequence for that access. The sequence holds each phase long enough to meet the RAM's minimum times for the chosen speed grade, and it ends with a one-cycle done pulse. For reads, the captured byte is presented on the host read-data port.

Every timing minimum is a nanosecond figure picked by a speed-grade parameter. It becomes a cycle count by ceiling division by the clock period, with a floor of one cycle. Writes are controlled by the write strobe, and the read enable stays high while a write runs. After every read, a turnaround gap lets the RAM's data pins float before the controller drives the bus again.

The host can also park the RAM in a low-power retention state. While the retention request is high and the controller is idle, both selects are held inactive. When the request drops, a recovery lockout of millisecond scale must expire before the next access is accepted. Requests that arrive while the controller is not ready are dropped.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is low and directly after it, the active-low select is 1, the active-high select is 0, the write strobe and read enable are 1, the data-bus drive enable is 0, done is 0 and ready is 1.
- R2: A read holds the active-low select at 0, the active-high select at 1, the read enable at 0 and the write strobe at 1, with a stable address, for at least ceil(max(address access, enable-to-valid)/period) cycles before the byte is captured. host_rdata then equals the addressed memory byte in the cycle where done is 1.
- R3: During a write, the write strobe is 0 for at least ceil(max(write pulse, data setup)/period) cycles. Only both selects active permit the write strobe at 0. The read enable stays 1 throughout. The bus is driven with stable data, and the address equals the requested one.
- R4: For a write, the address-valid-to-strobe-end time is at least ceil(address-valid-to-end-of-write/period) cycles. The selects stay active for at least ceil(write cycle/period) cycles.
- R5: The data-bus drive enable never becomes 1 sooner than ceil(output float time/period) cycles after the read enable was last 0.
- R6: Each accepted request gives exactly one done pulse, one cycle wide. A request while ready is 0 is ignored: it gives no done and does not alter memory.
- R7: When the controller is idle with the retention request at 1, it enters retention. Both selects are then inactive, ready is 0, and host requests are ignored.
- R8: After the retention request falls, ready stays 0 for ceil(recovery time/period) cycles. Both selects stay inactive during that time, and ready then returns to 1.
- R9: In idle, a host request takes priority over a retention request that arrives in the same cycle. Retention is entered after that access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle access request, taken when host_ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Access address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Captured read data |
| host_done | output | 1 | One-cycle completion pulse |
| host_ready | output | 1 | Controller idle and able to accept a request |
| ret_req | input | 1 | Level request for low-power retention |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_sel_n | output | 1 | Active-low RAM select |
| mem_sel | output | 1 | Active-high RAM select |
| mem_wstb_n | output | 1 | Active-low write strobe |
| mem_rden_n | output | 1 | Active-low read (output) enable |
| mem_dq_out | output | DATA_W | Data driven towards the RAM |
| mem_dq_in | input | DATA_W | Data returned from the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The hardest case is the recovery lockout under pressure. The controller must refuse a request that arrives inside retention or recovery, and it must not count the lockout short. The stimulus raises a retention request in the same cycle as a read to show the priority. It then fires writes during retention and mid-recovery to an address whose content is known, and counts the not-ready cycles exactly. A later read-back shows that those writes never landed. The bus turnaround is exercised by a write issued straight after a read, while the bench's RAM model returns garbage until the access time has elapsed.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_RD_WAIT,
      ST_RD_CAPTURE,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOVER,
      ST_TURNAROUND,
      ST_RETENTION,
      ST_RECOVERY
   } ctrl_state_t;

   function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned period);
      int unsigned r;
      r = (ns + period - 1) / period;
      return (r == 0) ? 1 : r;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // address access / read cycle
   function automatic int unsigned ns_access(input int unsigned grade);
      case (grade)
         0: return 55;
         1: return 70;
         default: return 100;
      endcase
   endfunction

   function automatic int unsigned ns_rden_valid(input int unsigned grade);
      case (grade)
         0: return 30;
         1: return 40;
         default: return 50;
      endcase
   endfunction

   function automatic int unsigned ns_wr_cycle(input int unsigned grade);
      case (grade)
         0: return 55;
         1: return 70;
         default: return 100;
      endcase
   endfunction

   function automatic int unsigned ns_wr_pulse(input int unsigned grade);
      case (grade)
         0: return 40;
         1: return 50;
         default: return 70;
      endcase
   endfunction

   function automatic int unsigned ns_addr_to_end(input int unsigned grade);
      case (grade)
         0: return 50;
         1: return 60;
         default: return 70;
      endcase
   endfunction

   function automatic int unsigned ns_data_setup(input int unsigned grade);
      case (grade)
         0: return 25;
         1: return 30;
         default: return 40;
      endcase
   endfunction

   function automatic int unsigned ns_float(input int unsigned grade);
      case (grade)
         0: return 25;
         1: return 25;
         default: return 35;
      endcase
   endfunction

endpackage

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
   import sram_strobe_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned RD_WAIT_CYC  = 13,
   parameter int unsigned WR_SETUP_CYC = 3,
   parameter int unsigned WR_PULSE_CYC = 10,
   parameter int unsigned WR_REC_CYC   = 1,
   parameter int unsigned TURN_CYC     = 7,
   parameter int unsigned REC_CYC      = 100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_req,
   input  logic        host_wr,
   input  logic        ret_req,
   output ctrl_state_t state,
   output logic        last_cyc,
   output logic        accept,
   output logic        capture
);

   logic [CNT_W-1:0] cnt;

   assign last_cyc = (cnt == '0);
   assign accept   = (state == ST_IDLE) && host_req;
   assign capture  = (state == ST_RD_WAIT) && last_cyc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (host_req) begin
                  if (host_wr) begin
                     state <= ST_WR_SETUP;
                     cnt   <= CNT_W'(WR_SETUP_CYC - 1);
                  end else begin
                     state <= ST_RD_SETUP;
                     cnt   <= '0;
                  end
               end else if (ret_req) begin
                  state <= ST_RETENTION;
               end
            end
            ST_RD_SETUP: begin
               state <= ST_RD_WAIT;
               cnt   <= CNT_W'(RD_WAIT_CYC - 1);
            end
            ST_RD_WAIT: begin
               if (last_cyc) state <= ST_RD_CAPTURE;
               else          cnt   <= cnt - 1'b1;
            end
            ST_RD_CAPTURE: begin
               state <= ST_TURNAROUND;
               cnt   <= CNT_W'(TURN_CYC - 1);
            end
            ST_TURNAROUND: begin
               if (last_cyc) state <= ST_IDLE;
               else          cnt   <= cnt - 1'b1;
            end
            ST_WR_SETUP: begin
               if (last_cyc) begin
                  state <= ST_WR_PULSE;
                  cnt   <= CNT_W'(WR_PULSE_CYC - 1);
               end else cnt <= cnt - 1'b1;
            end
            ST_WR_PULSE: begin
               if (last_cyc) begin
                  state <= ST_WR_RECOVER;
                  cnt   <= CNT_W'(WR_REC_CYC - 1);
               end else cnt <= cnt - 1'b1;
            end
            ST_WR_RECOVER: begin
               if (last_cyc) state <= ST_IDLE;
               else          cnt   <= cnt - 1'b1;
            end
            ST_RETENTION: begin
               if (!ret_req) begin
                  state <= ST_RECOVERY;
                  cnt   <= CNT_W'(REC_CYC - 1);
               end
            end
            ST_RECOVERY: begin
               if (last_cyc) state <= ST_IDLE;
               else          cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_RECOVERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RECOVERY && !last_cyc) |=> (state == ST_RECOVERY)); // R8

   AST_REQ_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && host_req && ret_req) |=> (state != ST_RETENTION)); // R9

   AST_RET_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RETENTION && ret_req) |=> (state == ST_RETENTION)); // R7

endmodule

// File: rtl/sram_strobe_datapath.sv
module sram_strobe_datapath #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [DATA_W-1:0] host_rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         host_rdata <= '0;
      end else begin
         if (accept) begin
            mem_addr   <= host_addr;
            mem_dq_out <= host_wdata;
         end
         if (capture) host_rdata <= mem_dq_in;
      end
   end

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(mem_addr)); // R3

endmodule

// File: rtl/sram_strobe_pins.sv
module sram_strobe_pins
   import sram_strobe_pkg::*;
#(
   parameter int unsigned TURN_CYC = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  ctrl_state_t state,
   input  logic        last_cyc,
   output logic        mem_sel_n,
   output logic        mem_sel,
   output logic        mem_wstb_n,
   output logic        mem_rden_n,
   output logic        mem_dq_oe,
   output logic        host_done,
   output logic        host_ready
);

   localparam int unsigned FL_W = $clog2(TURN_CYC + 1);

   always_comb begin
      mem_sel_n  = 1'b1;
      mem_sel    = 1'b0;
      mem_wstb_n = 1'b1;
      mem_rden_n = 1'b1;
      mem_dq_oe  = 1'b0;
      case (state)
         ST_RD_SETUP, ST_RD_WAIT: begin
            mem_sel_n  = 1'b0;
            mem_sel    = 1'b1;
            mem_rden_n = 1'b0;
         end
         ST_WR_SETUP, ST_WR_RECOVER: begin
            mem_sel_n = 1'b0;
            mem_sel   = 1'b1;
            mem_dq_oe = 1'b1;
         end
         ST_WR_PULSE: begin
            mem_sel_n  = 1'b0;
            mem_sel    = 1'b1;
            mem_wstb_n = 1'b0;
            mem_dq_oe  = 1'b1;
         end
         default: ;
      endcase
   end

   assign host_ready = (state == ST_IDLE);
   assign host_done  = (state == ST_RD_CAPTURE) ||
                       ((state == ST_WR_RECOVER) && last_cyc);

   // cycles since the RAM could last have driven its data pins
   logic [FL_W-1:0] float_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                         float_cnt <= FL_W'(TURN_CYC);
      else if (!mem_rden_n)               float_cnt <= '0;
      else if (float_cnt != FL_W'(TURN_CYC)) float_cnt <= float_cnt + 1'b1;
   end

   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (float_cnt == FL_W'(TURN_CYC))); // R5

   AST_WSTB_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wstb_n |-> (!mem_sel_n && mem_sel)); // R3

   AST_RDEN_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wstb_n |-> (mem_rden_n && mem_dq_oe)); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |=> !host_done); // R6

   AST_RET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RETENTION || state == ST_RECOVERY) |-> (mem_sel_n && !mem_sel && !host_ready)); // R7

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_strobe_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned SPEED_GRADE   = 0,
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned RECOVERY_NS   = 5000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_done,
   output logic              host_ready,
   input  logic              ret_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_wstb_n,
   output logic              mem_rden_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int unsigned N_RD   = max2(cycles_for(ns_access(SPEED_GRADE), CLK_PERIOD_NS),
                                         cycles_for(ns_rden_valid(SPEED_GRADE), CLK_PERIOD_NS));
   localparam int unsigned N_WP   = max2(cycles_for(ns_wr_pulse(SPEED_GRADE), CLK_PERIOD_NS),
                                         cycles_for(ns_data_setup(SPEED_GRADE), CLK_PERIOD_NS));
   localparam int unsigned N_AW   = cycles_for(ns_addr_to_end(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned N_WC   = cycles_for(ns_wr_cycle(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned N_HZ   = cycles_for(ns_float(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned N_REC  = cycles_for(RECOVERY_NS, CLK_PERIOD_NS);
   localparam int unsigned RD_WAIT  = (N_RD > 1) ? N_RD - 1 : 1;
   localparam int unsigned WR_SETUP = (N_AW > N_WP) ? N_AW - N_WP : 1;
   localparam int unsigned WR_REC   = (N_WC > WR_SETUP + N_WP) ? N_WC - WR_SETUP - N_WP : 1;
   localparam int unsigned MAX_CNT  = max2(max2(RD_WAIT, WR_SETUP),
                                           max2(max2(N_WP, WR_REC), max2(N_HZ, N_REC)));
   localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);

   generate
      if (SPEED_GRADE > 2) begin : g_bad_grade
         $error("SPEED_GRADE must be 0, 1 or 2");
      end
      if (CLK_PERIOD_NS == 0) begin : g_bad_period
         $error("CLK_PERIOD_NS must be nonzero");
      end
      if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
         $error("ADDR_W and DATA_W must be nonzero");
      end
   endgenerate

   ctrl_state_t state;
   logic        last_cyc;
   logic        accept;
   logic        capture;

   sram_strobe_fsm #(
      .CNT_W        (CNT_W),
      .RD_WAIT_CYC  (RD_WAIT),
      .WR_SETUP_CYC (WR_SETUP),
      .WR_PULSE_CYC (N_WP),
      .WR_REC_CYC   (WR_REC),
      .TURN_CYC     (N_HZ),
      .REC_CYC      (N_REC)
   ) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_req (host_req),
      .host_wr  (host_wr),
      .ret_req  (ret_req),
      .state    (state),
      .last_cyc (last_cyc),
      .accept   (accept),
      .capture  (capture)
   );

   sram_strobe_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_datapath (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .host_rdata (host_rdata)
   );

   sram_strobe_pins #(
      .TURN_CYC (N_HZ)
   ) i_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .last_cyc   (last_cyc),
      .mem_sel_n  (mem_sel_n),
      .mem_sel    (mem_sel),
      .mem_wstb_n (mem_wstb_n),
      .mem_rden_n (mem_rden_n),
      .mem_dq_oe  (mem_dq_oe),
      .host_done  (host_done),
      .host_ready (host_ready)
   );

   AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rden_n && $past(!mem_rden_n)) |-> $stable(mem_addr)); // R2

   AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wstb_n && $past(!mem_wstb_n)) |-> $stable(mem_dq_out)); // R3

   AST_READY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (mem_sel_n && !mem_sel && !mem_dq_oe)); // R6

endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

   localparam int unsigned PER  = 4;
   localparam int unsigned RECN = 400;

   function automatic int unsigned cdiv(input int unsigned ns);
      int unsigned r;
      r = (ns + PER - 1) / PER;
      return (r == 0) ? 1 : r;
   endfunction

   // grade 0 figures
   localparam int unsigned NAA  = cdiv(55);
   localparam int unsigned NWP  = (cdiv(40) > cdiv(25)) ? cdiv(40) : cdiv(25);
   localparam int unsigned NAW  = cdiv(50);
   localparam int unsigned NWC  = cdiv(55);
   localparam int unsigned NHZ  = cdiv(25);
   localparam int unsigned NREC = cdiv(RECN);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_wr = 1'b0;
   logic [15:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_done;
   logic        host_ready;
   logic        ret_req = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_sel_n, mem_sel, mem_wstb_n, mem_rden_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in;

   always #2 clk = ~clk;

   sram_strobe_ctrl #(
      .SPEED_GRADE   (0),
      .CLK_PERIOD_NS (PER),
      .RECOVERY_NS   (RECN)
   ) i_sram_strobe_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_done(host_done), .host_ready(host_ready), .ret_req(ret_req),
      .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
      .mem_wstb_n(mem_wstb_n), .mem_rden_n(mem_rden_n), .mem_dq_out(mem_dq_out),
      .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // RAM model: data valid only after access time
   logic [7:0] model_mem [0:255];
   int         acc = 0;
   wire        selected  = !mem_sel_n && mem_sel;
   wire        rd_active = selected && !mem_rden_n && mem_wstb_n;

   initial for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;

   always @(posedge clk) begin
      acc <= rd_active ? acc + 1 : 0;
      if (selected && !mem_wstb_n) model_mem[mem_addr[7:0]] <= mem_dq_out;
   end

   assign mem_dq_in = (rd_active && acc >= int'(NAA) - 1) ? model_mem[mem_addr[7:0]] : 8'hEE;

   // scoreboard
   typedef struct { bit is_rd; logic [7:0] data; } sb_t;
   sb_t        sbq[$];
   logic [7:0] ref_mem [0:255];
   initial for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;

   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (host_done && prev_done) check(1'b0, "R6 done width", 2, 1);
         if (host_done) begin
            if (sbq.size() == 0) check(1'b0, "R6 unexpected done", 1, 0);
            else begin
               sb_t it;
               it = sbq.pop_front();
               if (it.is_rd) check(host_rdata == it.data, "R2 read data", host_rdata, it.data);
            end
         end
      end
      prev_done = host_done;
   end

   // write and turnaround protocol monitor
   int   wlow = 0, selc = 0, since_rd = 1000;
   bit   prev_wlow = 0, prev_oe = 0, wr_ep = 0, prev_sel = 0, wbad = 0;
   logic [15:0] w_addr;
   logic [7:0]  w_data;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe && !prev_oe) check(since_rd >= int'(NHZ), "R5 turnaround", since_rd, NHZ);
         if (selected) selc++;
         if (!mem_wstb_n) begin
            if (prev_wlow && (mem_addr != w_addr || mem_dq_out != w_data)) wbad = 1;
            if (!mem_dq_oe || !mem_rden_n) wbad = 1;
            w_addr = mem_addr; w_data = mem_dq_out;
            wlow++; wr_ep = 1;
         end else if (prev_wlow) begin
            check(wlow >= int'(NWP), "R3 strobe width", wlow, NWP);
            check(!wbad, "R3 stable during strobe", int'(wbad), 0);
            check(selc - 0 >= int'(NAW) + 0 - 0 - 1 + 1 - (selected ? 1 : 0),
                  "R4 address to strobe end", selc, NAW);
            wlow = 0; wbad = 0;
         end
         if (!selected && prev_sel) begin
            if (wr_ep) check(selc >= int'(NWC), "R4 write cycle", selc, NWC);
            wr_ep = 0;
         end
         if (!selected) selc = 0;
         since_rd = rd_active ? 0 : ((since_rd < 1000) ? since_rd + 1 : since_rd);
         prev_wlow = !mem_wstb_n;
         prev_oe   = mem_dq_oe;
         prev_sel  = selected;
      end
   end

   task automatic wait_ready();
      while (!host_ready) @(negedge clk);
   endtask

   task automatic wait_empty();
      while (sbq.size() != 0) @(negedge clk);
   endtask

   task automatic host_write(input logic [15:0] a, input logic [7:0] d);
      sb_t it;
      wait_ready();
      host_req = 1; host_wr = 1; host_addr = a; host_wdata = d;
      it.is_rd = 0; it.data = d; sbq.push_back(it);
      ref_mem[a[7:0]] = d;
      @(negedge clk);
      host_req = 0;
      check(mem_addr == a, "R3 write address", mem_addr, a);
      wait_empty();
   endtask

   task automatic host_read(input logic [15:0] a);
      sb_t it;
      wait_ready();
      host_req = 1; host_wr = 0; host_addr = a;
      it.is_rd = 1; it.data = ref_mem[a[7:0]]; sbq.push_back(it);
      @(negedge clk);
      host_req = 0;
      wait_empty();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      report();
      $finish;
   end

   initial begin
      int cnt;
      repeat (4) @(negedge clk);
      check(mem_sel_n && !mem_sel && mem_wstb_n && mem_rden_n && !mem_dq_oe,
            "R1 strobes in reset", {mem_sel_n, mem_sel, mem_wstb_n, mem_rden_n, mem_dq_oe}, 5'b10110);
      check(!host_done && host_ready, "R1 done/ready in reset", {host_done, host_ready}, 2'b01);
      rst_n = 1;
      @(negedge clk);
      check(host_ready && mem_sel_n && !mem_sel, "R1 after reset", host_ready, 1);

      // R3 R4 writes with several patterns
      host_write(16'h0010, 8'hA5);
      host_write(16'h1234, 8'h5A);
      host_write(16'hFFFF, 8'hFF);
      host_write(16'h0000, 8'h00);
      host_write(16'h8001, 8'h3C);
      // R2 read-back
      host_read(16'h0010);
      host_read(16'h1234);
      host_read(16'hFFFF);
      host_read(16'h0000);
      host_read(16'h8001);
      // R5 write straight after a read
      host_read(16'h1234);
      host_write(16'h0042, 8'hC3);
      host_read(16'h0042);

      // R6 request while busy is ignored
      begin
         sb_t it;
         wait_ready();
         host_req = 1; host_wr = 0; host_addr = 16'h0042;
         it.is_rd = 1; it.data = ref_mem[8'h42]; sbq.push_back(it);
         @(negedge clk); host_req = 0;
         @(negedge clk);
         host_req = 1; host_wr = 1; host_addr = 16'h0042; host_wdata = 8'h11;
         @(negedge clk); host_req = 0;
         wait_empty();
      end
      host_read(16'h0042);

      // R9 priority, then R7 retention
      wait_ready();
      begin
         sb_t it;
         host_req = 1; host_wr = 0; host_addr = 16'h0010; ret_req = 1;
         it.is_rd = 1; it.data = ref_mem[8'h10]; sbq.push_back(it);
         @(negedge clk); host_req = 0;
         check(!mem_rden_n && !host_ready, "R9 request wins", mem_rden_n, 0);
         wait_empty();
      end
      repeat (NHZ + 4) @(negedge clk);
      check(!host_ready && mem_sel_n && !mem_sel, "R7 retention entered",
            {host_ready, mem_sel_n, mem_sel}, 3'b010);
      host_req = 1; host_wr = 1; host_addr = 16'h0010; host_wdata = 8'h99;
      @(negedge clk); host_req = 0;
      cnt = 0;
      repeat (5) begin
         @(negedge clk);
         if (!mem_sel_n || mem_sel || !mem_wstb_n || host_done) cnt++;
      end
      check(cnt == 0, "R7 request ignored in retention", cnt, 0);

      // R8 recovery lockout
      ret_req = 0;
      cnt = 0;
      @(negedge clk);
      while (!host_ready && cnt < 100000) begin
         if (!mem_sel_n || mem_sel) check(1'b0, "R8 select during recovery", 1, 0);
         cnt++;
         if (cnt == 10) begin host_req = 1; host_wr = 1; host_addr = 16'h0010; host_wdata = 8'h77; end
         if (cnt == 11) host_req = 0;
         @(negedge clk);
      end
      check(cnt == int'(NREC), "R8 recovery length", cnt, NREC);
      host_read(16'h0010);
      check(ref_mem[8'h10] == 8'hA5, "R7 memory unchanged", ref_mem[8'h10], 8'hA5);
      repeat (20) @(negedge clk);
      check(sbq.size() == 0, "R6 no stray done", sbq.size(), 0);
      report();
      $finish;
   end

endmodule